// File: doc/BRIEF.md
# Gate-Rail Power-Up Sequencer

This block is the digital controller that brings up and tears down the supply rails of a display bias generator. An active-low shutdown input and a comparator flag are its inputs. The comparator flag goes high once the negative gate rail has passed its turn-on threshold. From these the block drives five outputs: a gate for the oscillator that clocks the charge pumps, an enable for the negative-rail pump, an enable for the positive-rail pump, an enable for the rail discharge switches, and a one-cycle strobe. The strobe reloads the amplitude and centre-voltage DAC registers with their default codes.

Both asynchronous inputs pass through two-flop synchronizers. A registered state machine then walks through five states in order: shutdown, a single release cycle, negative ramp, positive ramp and run. The positive pump is never enabled before the synchronized comparator flag is seen while the negative pump is already running. A programmable watchdog raises a sticky fault if the flag does not arrive within a set number of cycles of the negative ramp. When shutdown is asserted, the machine returns to the shutdown state from any state, drops every enable and starts the discharge.

Top module: `gateRailSeq`

## Requirements
- R1: After synchronous reset (rstN low at a clock edge) the block sits in shutdown: dischargeEn is 1, and oscEn, negPumpEn, posPumpEn, dacPreset and fault are 0.
- R2: While the synchronized shutdown input is low, the oscillator gate and both pump enables stay 0 and dischargeEn stays 1.
- R3: When shdnN rises, the outputs change after the third rising clock edge. They then hold for exactly one cycle with oscEn 1, dischargeEn 0 and both pump enables 0.
- R4: In the cycle after the release cycle, negPumpEn and oscEn are both 1 and posPumpEn is 0.
- R5: During the negative ramp, posPumpEn stays 0 while negRailOk is low. After negRailOk rises, posPumpEn goes to 1 after the third rising clock edge.
- R6: posPumpEn is 1 only while negPumpEn is 1. A negRailOk that is already high when shutdown is left still lets at least one negative-ramp cycle pass before posPumpEn rises.
- R7: If shdnN falls in any non-shutdown state, the outputs change after the third rising edge to dischargeEn 1 with all pump enables and oscEn 0.
- R8: dischargeEn is never 1 in a cycle where oscEn, negPumpEn or posPumpEn is 1.
- R9: dacPreset is 1 for exactly one cycle, the release cycle that follows shutdown, and is 0 at all other times.
- R10: Let timeoutLimit be N ≥ 1 and suppose negRailOk stays low. fault then rises after the Nth rising edge following entry to the negative ramp. It stays 1 through the rest of the ramp and the later states.
- R11: fault returns to 0 one cycle after the shutdown outputs appear. A timeoutLimit of 0 disables the fault.
- R12: Once posPumpEn is 1, a later drop of negRailOk has no effect, and both pump enables stay on until shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous active-low reset |
| shdnN | input | 1 | Asynchronous active-low shutdown request |
| negRailOk | input | 1 | Asynchronous comparator flag: negative gate rail past threshold |
| timeoutLimit | input | TIMER_W | Negative-ramp fault window in cycles, 0 disables |
| oscEn | output | 1 | Gate for the charge-pump oscillator |
| negPumpEn | output | 1 | Negative gate rail pump enable |
| posPumpEn | output | 1 | Positive gate rail pump enable |
| dischargeEn | output | 1 | Rail discharge switch enable |
| dacPreset | output | 1 | One-cycle strobe loading DAC default codes |
| fault | output | 1 | Sticky flag: negative rail did not reach threshold in time |

## Verification
Every state has its own output pattern, except the positive ramp and run, which share one. A wrong state or a wrong transition therefore shows on the ports in the cycle after the edge that caused it. A skipped release cycle shows as a missing dacPreset pulse. Positive-pump enables that come too early appear as posPumpEn within one cycle of negPumpEn. A bad timeout counter moves the fault edge away from the Nth cycle of the ramp. Because the synchronizers and the state register are in series, each stimulus is sampled at exactly its third edge. This catches a missing or extra flop.

// File: rtl/gateRailSeqPkg.sv
package gateRailSeqPkg;

  typedef enum logic [2:0] {
    ST_SHUTDOWN = 3'd0,
    ST_RELEASE  = 3'd1,
    ST_NEG_RAMP = 3'd2,
    ST_POS_RAMP = 3'd3,
    ST_RUN      = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic settleRun;
    logic faultClr;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic shdnActive;
    logic negOk;
    logic settleDone;
  } dpSts_t;

endpackage

// File: rtl/gateRailSeqSync.sv
module gateRailSeqSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain <= {chain[STAGES-2:0], dIn};
    end
  end

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/gateRailSeqDp.sv
module gateRailSeqDp
  import gateRailSeqPkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int POS_SETTLE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               shdnN,
  input  logic               negRailOk,
  input  logic [TIMER_W-1:0] timeoutLimit,
  input  dpCtl_t             ctl,
  output dpSts_t             sts,
  output logic               fault
);

  localparam int SETTLE_W = (POS_SETTLE > 1) ? $clog2(POS_SETTLE) : 1;
  localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(POS_SETTLE - 1);
  localparam int NUM_SYNC = 2;

  logic [NUM_SYNC-1:0] rawIn;
  logic [NUM_SYNC-1:0] syncOut;
  logic [TIMER_W-1:0]  timerCnt;
  logic [SETTLE_W-1:0] settleCnt;
  logic                limitOn;
  logic                timerLast;

  assign rawIn = {negRailOk, shdnN};

  // shutdown line resets to "asserted" (0), comparator resets to "not ok"
  for (genvar gi = 0; gi < NUM_SYNC; gi++) begin : g_sync
    gateRailSeqSync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b0)
    ) sync_i (
      .clk (clk),
      .rstN(rstN),
      .dIn (rawIn[gi]),
      .qOut(syncOut[gi])
    );
  end

  assign limitOn   = (timeoutLimit != '0);
  assign timerLast = limitOn && (timerCnt == timeoutLimit - TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || ctl.timerClr) begin
      timerCnt <= '0;
    end else if (ctl.timerRun && limitOn && (timerCnt != timeoutLimit)) begin
      timerCnt <= timerCnt + TIMER_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.faultClr) begin
      fault <= 1'b0;
    end else if (ctl.timerRun && timerLast) begin
      fault <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.settleRun) begin
      settleCnt <= '0;
    end else if (settleCnt != SETTLE_LAST) begin
      settleCnt <= settleCnt + SETTLE_W'(1);
    end
  end

  assign sts.shdnActive = !syncOut[0];
  assign sts.negOk      = syncOut[1];
  assign sts.settleDone = ctl.settleRun && (settleCnt == SETTLE_LAST);

endmodule

// File: rtl/gateRailSeqCtrl.sv
module gateRailSeqCtrl
  import gateRailSeqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpSts_t sts,
  output dpCtl_t ctl,
  output logic   oscEn,
  output logic   negPumpEn,
  output logic   posPumpEn,
  output logic   dischargeEn,
  output logic   dacPreset
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (sts.shdnActive) begin
      stateNext = ST_SHUTDOWN;
    end else begin
      case (state)
        ST_SHUTDOWN: stateNext = ST_RELEASE;
        ST_RELEASE:  stateNext = ST_NEG_RAMP;
        ST_NEG_RAMP: if (sts.negOk) stateNext = ST_POS_RAMP;
        ST_POS_RAMP: if (sts.settleDone) stateNext = ST_RUN;
        ST_RUN:      stateNext = ST_RUN;
        default:     stateNext = ST_SHUTDOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_SHUTDOWN;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    ctl.timerClr  = (state != ST_NEG_RAMP);
    ctl.timerRun  = (state == ST_NEG_RAMP) && !sts.negOk;
    ctl.settleRun = (state == ST_POS_RAMP);
    ctl.faultClr  = (state == ST_SHUTDOWN);
  end

  always_comb begin
    dischargeEn = (state == ST_SHUTDOWN);
    oscEn       = (state != ST_SHUTDOWN);
    dacPreset   = (state == ST_RELEASE);
    negPumpEn   = (state == ST_NEG_RAMP) || (state == ST_POS_RAMP) || (state == ST_RUN);
    posPumpEn   = (state == ST_POS_RAMP) || (state == ST_RUN);
  end

endmodule

// File: rtl/gateRailSeq.sv
module gateRailSeq
  import gateRailSeqPkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int POS_SETTLE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               shdnN,
  input  logic               negRailOk,
  input  logic [TIMER_W-1:0] timeoutLimit,
  output logic               oscEn,
  output logic               negPumpEn,
  output logic               posPumpEn,
  output logic               dischargeEn,
  output logic               dacPreset,
  output logic               fault
);

  dpCtl_t ctl;
  dpSts_t sts;

  gateRailSeqDp #(
    .TIMER_W    (TIMER_W),
    .POS_SETTLE (POS_SETTLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .shdnN       (shdnN),
    .negRailOk   (negRailOk),
    .timeoutLimit(timeoutLimit),
    .ctl         (ctl),
    .sts         (sts),
    .fault       (fault)
  );

  gateRailSeqCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sts        (sts),
    .ctl        (ctl),
    .oscEn      (oscEn),
    .negPumpEn  (negPumpEn),
    .posPumpEn  (posPumpEn),
    .dischargeEn(dischargeEn),
    .dacPreset  (dacPreset)
  );

endmodule

// File: rtl/gateRailSeqChk.sv
module gateRailSeqChk (
  input logic clk,
  input logic rstN,
  input logic oscEn,
  input logic negPumpEn,
  input logic posPumpEn,
  input logic dischargeEn,
  input logic dacPreset,
  input logic fault
);

  p_discharge_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    dischargeEn |-> !(oscEn || negPumpEn || posPumpEn));

  p_pos_needs_neg_r6: assert property (@(posedge clk) disable iff (!rstN)
    posPumpEn |-> negPumpEn);

  p_pos_after_neg_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(posPumpEn) |-> $past(negPumpEn));

  p_preset_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    dacPreset |=> !dacPreset);

  p_preset_from_shd_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacPreset) |-> $past(dischargeEn));

  p_neg_follows_preset_r4: assert property (@(posedge clk) disable iff (!rstN)
    dacPreset |=> (negPumpEn || dischargeEn));

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> (fault || dischargeEn));

  p_fault_cleared_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dischargeEn && $past(dischargeEn)) |-> !fault);

  p_pos_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    posPumpEn |=> (posPumpEn || dischargeEn));

endmodule

bind gateRailSeq gateRailSeqChk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .oscEn      (oscEn),
  .negPumpEn  (negPumpEn),
  .posPumpEn  (posPumpEn),
  .dischargeEn(dischargeEn),
  .dacPreset  (dacPreset),
  .fault      (fault)
);

// File: tb/gateRailSeq_tb_top.sv
`timescale 1ns/1ps
module gateRailSeq_tb_top;

  localparam int TIMER_W = 16;
  localparam int NEG_DLY = 6;
  // output vector order: {oscEn, negPumpEn, posPumpEn, dischargeEn, dacPreset, fault}
  localparam logic [5:0] O_SHD = 6'b000100;
  localparam logic [5:0] O_REL = 6'b100010;
  localparam logic [5:0] O_NEG = 6'b110000;
  localparam logic [5:0] O_POS = 6'b111000;
  localparam logic [5:0] O_FLT = 6'b000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shdnN = 1'b0;
  logic manOk = 1'b0;
  logic modelOn = 1'b0;
  logic modelOk = 1'b0;
  logic negRailOk;
  logic [TIMER_W-1:0] timeoutLimit = '0;
  logic oscEn, negPumpEn, posPumpEn, dischargeEn, dacPreset, fault;
  int modelCnt = 0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gateRailSeq #(.TIMER_W(TIMER_W)) dut_i (
    .clk(clk), .rstN(rstN), .shdnN(shdnN), .negRailOk(negRailOk),
    .timeoutLimit(timeoutLimit), .oscEn(oscEn), .negPumpEn(negPumpEn),
    .posPumpEn(posPumpEn), .dischargeEn(dischargeEn), .dacPreset(dacPreset),
    .fault(fault)
  );

  // negative rail model: reaches threshold NEG_DLY cycles after its pump runs
  always @(negedge clk) begin
    if (!negPumpEn) begin
      modelCnt <= 0;
      modelOk  <= 1'b0;
    end else begin
      if (modelCnt < NEG_DLY) modelCnt <= modelCnt + 1;
      modelOk <= (modelCnt >= NEG_DLY - 1);
    end
  end
  assign negRailOk = modelOn ? modelOk : manOk;

  function automatic logic [5:0] outs();
    return {oscEn, negPumpEn, posPumpEn, dischargeEn, dacPreset, fault};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rstN = 1'b0; shdnN = 1'b0; manOk = 1'b0; modelOn = 1'b0;
    tick(4);
    @(negedge clk); rstN = 1'b1;
    tick(1);
    chk("R1 reset outputs", outs(), O_SHD);
    tick(5);
    chk("R2 held in shutdown", outs(), O_SHD);
  endtask

  task automatic t_powerup();
    timeoutLimit = 16'd200; modelOn = 1'b1;
    @(negedge clk); shdnN = 1'b1;
    tick(2);
    chk("R2 still shutdown before sync", outs(), O_SHD);
    tick(1);
    chk("R3 R9 release cycle with preset", outs(), O_REL);
    tick(1);
    chk("R4 R9 negative ramp", outs(), O_NEG);
    tick(7);
    chk("R5 positive held before flag", outs(), O_NEG);
    tick(1);
    chk("R5 positive enabled after flag", outs(), O_POS);
    tick(20);
    chk("R12 run keeps both pumps", outs(), O_POS);
    @(negedge clk); modelOn = 1'b0; manOk = 1'b0;
    tick(5);
    chk("R12 flag drop ignored", outs(), O_POS);
  endtask

  task automatic t_shutdown();
    @(negedge clk); shdnN = 1'b0;
    tick(2);
    chk("R7 not yet through sync", outs(), O_POS);
    tick(1);
    chk("R7 shutdown from run", outs(), O_SHD);
    chk("R8 discharge exclusive", {31'd0, dischargeEn && !(oscEn || negPumpEn || posPumpEn)}, 32'd1);
    tick(3);
    chk("R2 shutdown stable", outs(), O_SHD);
  endtask

  task automatic t_fault();
    timeoutLimit = 16'd10; modelOn = 1'b0; manOk = 1'b0;
    @(negedge clk); shdnN = 1'b1;
    tick(4);
    chk("R4 ramp entered", outs(), O_NEG);
    tick(9);
    chk("R10 no fault before N", outs(), O_NEG);
    tick(1);
    chk("R10 fault at N", outs(), O_NEG | O_FLT);
    tick(10);
    chk("R10 R5 fault sticky, positive held", outs(), O_NEG | O_FLT);
    @(negedge clk); manOk = 1'b1;
    tick(2);
    chk("R5 positive not before third edge", outs(), O_NEG | O_FLT);
    tick(1);
    chk("R5 R10 positive after late flag", outs(), O_POS | O_FLT);
    @(negedge clk); shdnN = 1'b0;
    tick(3);
    chk("R7 shutdown, fault pending clear", outs(), O_SHD | O_FLT);
    tick(1);
    chk("R11 fault cleared", outs(), O_SHD);
    @(negedge clk); manOk = 1'b0;
  endtask

  task automatic t_noLimit();
    timeoutLimit = 16'd0;
    @(negedge clk); shdnN = 1'b1;
    tick(4 + 64);
    chk("R11 limit zero never faults", outs(), O_NEG);
    @(negedge clk); shdnN = 1'b0;
    tick(2);
    chk("R7 negative ramp before sync", outs(), O_NEG);
    tick(1);
    chk("R7 shutdown from negative ramp", outs(), O_SHD);
  endtask

  task automatic t_abortRelease();
    timeoutLimit = 16'd50;
    @(negedge clk); shdnN = 1'b1;
    tick(3);
    chk("R3 release cycle", outs(), O_REL);
    @(negedge clk); shdnN = 1'b0;
    tick(1);
    chk("R9 preset single cycle", outs(), O_NEG);
    tick(1);
    chk("R9 no second preset", outs(), O_NEG);
    tick(1);
    chk("R7 shutdown right after release", outs(), O_SHD);
  endtask

  task automatic t_earlyFlag();
    @(negedge clk); manOk = 1'b1;
    tick(4);
    chk("R2 flag ignored in shutdown", outs(), O_SHD);
    @(negedge clk); shdnN = 1'b1;
    tick(3);
    chk("R6 release without positive", outs(), O_REL);
    tick(1);
    chk("R6 one negative cycle first", outs(), O_NEG);
    tick(1);
    chk("R6 positive after one ramp cycle", outs(), O_POS);
    @(negedge clk); shdnN = 1'b0;
    tick(3);
    chk("R7 shutdown from positive ramp", outs(), O_SHD);
    @(negedge clk); manOk = 1'b0;
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_shutdown();
    t_fault();
    t_noLimit();
    t_abortRelease();
    t_earlyFlag();
    tick(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule